// File: doc/BRIEF.md
# Distributed Multiprocessor Bus Arbiter

Each processor that shares one external bus carries a copy of this unit. A node drives a single request line, selected by its ID, and samples the whole request bus. From those samples every copy independently tracks the same ownership state: idle, owned by one node, turnaround, or held by an external host. The rules are identical and the inputs are shared, so all copies agree on which node is master without exchanging any other signal.

The priority among requesting nodes is either fixed or rotating, chosen by a shared mode input. A host request outranks all nodes. The node that last owned the bus answers the host with an active-low grant. A shared core-priority line lets a slave whose core needs the bus push a master off a background DMA transfer at the end of that transfer. A suspend input removes the bus drive enable on the cycle after it is seen. ID 0 makes the node run alone, with no arbitration against other nodes.

Top module: `mp_bus_arbiter`

## Requirements
- R1: A node with ID k (1..6) drives `req_o` as request line k. Line k appears as bit k-1 of `req_bus_i` on every node. `req_o` rises on the first clock edge at which `want_bus_i` is high (unless R8 holds it off).
- R2: Under fixed priority (`rotate_i` low), the lowest-numbered requesting line wins.
- R3: Under rotating priority (`rotate_i` high), the search starts at the line after the last owner and wraps after line 6. The last owner therefore ranks lowest. Before any ownership, line 1 ranks highest.
- R4: A master keeps the bus while its own request line is high. After the edge that samples that line low, there is one turnaround cycle with no master. There is never a direct handover from one master to another.
- R5: From idle or turnaround, the winning requester becomes master on the clock edge that samples the request bus. From that edge, `bus_master_o` is high on that node only.
- R6: A master drops its request only on a cycle where `xfer_done_i` is high and one of these holds: `want_bus_i` is low, `host_req_i` is high, or it is doing DMA (`dma_xfer_i`) while `core_prio_i` is high.
- R7: From idle or turnaround, a high `host_req_i` moves ownership to the host, ahead of any request line. The node that last owned the bus (line 1 if none has) then drives `host_gnt_no` low. The grant stays low until `host_req_i` is sampled low, and a turnaround cycle follows.
- R8: A non-master with a core (non-DMA) access pending drives `core_prio_o` high. A non-master doing DMA does not raise its request while `core_prio_i` is high.
- R9: `bus_drive_o` equals `bus_master_o` except on the cycle after `suspend_i` was sampled high, when it is low. `stall_o` is high while `want_bus_i` is high and either `suspend_i` is high or the node is not master.
- R10: After reset there is no master, every grant is high (inactive) and no request is driven.
- R11: Among nodes sharing one request bus, at most one has `bus_master_o` high on any cycle.
- R12: With ID 0, the node ignores `req_bus_i`. It arbitrates against its own request alone, as line 1, and drives `core_prio_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | ID_W | Node ID; 0 selects stand-alone mode |
| rotate_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| req_bus_i | input | NODES | Sampled request lines, bit k-1 is line k |
| req_o | output | 1 | This node's request line |
| want_bus_i | input | 1 | Local access pending |
| dma_xfer_i | input | 1 | Pending or current access is background DMA |
| xfer_done_i | input | 1 | Current access ends this cycle |
| host_req_i | input | 1 | Host bus request, active high |
| host_gnt_no | output | 1 | Host grant, active low |
| core_prio_i | input | 1 | Shared core-priority line |
| core_prio_o | output | 1 | This node's core-priority request |
| suspend_i | input | 1 | Suspend: three-state the bus next cycle |
| bus_master_o | output | 1 | This node owns the bus |
| bus_drive_o | output | 1 | Enable for address, data, select and strobe drivers |
| stall_o | output | 1 | Local access must wait |

## Verification
The assertions take for granted that `req_bus_i`, `host_req_i`, `rotate_i` and `core_prio_i` are the same on every node in the same cycle. They also assume that `node_id_i` is fixed and unique among active nodes, and that `req_bus_i` carries this node's own `req_o` at its own bit. The bench meets these conditions by building the request bus from the six `req_o` outputs and the core-priority line as the OR of the six `core_prio_o` outputs. It drives one shared copy of the host, mode and suspend inputs to every node, only at the falling edge. Per-node traffic (want, DMA, done) is random, so every node also sees access-end and preemption patterns that no node announces in advance.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_OWNED = 2'd1,
    ARB_TURN  = 2'd2,
    ARB_HOST  = 2'd3
  } arb_state_e;
endpackage

// File: rtl/arb_prio_pick.sv
`timescale 1ns/1ps
module arb_prio_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  input  logic          rotate_i,
  output logic [IW-1:0] win_o,
  output logic          any_o
);
  int start;
  int idx;

  // last_i is 1-based, so as a 0-based index it already points past the last owner
  always_comb begin
    win_o = '0;
    any_o = 1'b0;
    start = (rotate_i && (int'(last_i) < N)) ? int'(last_i) : 0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = start + k;
      if (idx >= N) idx = idx - N;
      if (!any_o && req_i[idx]) begin
        any_o = 1'b1;
        win_o = IW'(idx + 1);
      end
    end
  end

  always_comb begin
    a_r2_pick_valid: assert (!any_o || (win_o != '0 && req_i[win_o - 1'b1]));
    a_r3_last_lowest: assert (!(any_o && rotate_i && last_i != '0 && win_o == last_i)
                              || $countones(req_i) == 1);
  end
endmodule

// File: rtl/arb_tracker.sv
`timescale 1ns/1ps
module arb_tracker
  import arb_pkg::*;
#(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_vec_i,
  input  logic          host_req_i,
  input  logic          rotate_i,
  output arb_state_e    state_o,
  output logic [IW-1:0] owner_o,
  output logic [IW-1:0] last_o
);
  arb_state_e    state_q;
  logic [IW-1:0] owner_q, last_q, win;
  logic          any_req, owner_req;

  arb_prio_pick #(.N(N), .IW(IW)) u_pick (
    .req_i    (req_vec_i),
    .last_i   (last_q),
    .rotate_i (rotate_i),
    .win_o    (win),
    .any_o    (any_req)
  );

  assign owner_req = (owner_q != '0) && req_vec_i[owner_q - 1'b1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
      owner_q <= '0;
      last_q  <= '0;
    end else begin
      unique case (state_q)
        ARB_IDLE, ARB_TURN: begin
          if (host_req_i) begin
            state_q <= ARB_HOST;
          end else if (any_req) begin
            state_q <= ARB_OWNED;
            owner_q <= win;
          end else begin
            state_q <= ARB_IDLE;
          end
        end
        ARB_OWNED: begin
          if (!owner_req) begin
            state_q <= ARB_TURN;
            last_q  <= owner_q;
          end
        end
        ARB_HOST: begin
          if (!host_req_i) state_q <= ARB_TURN;
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign owner_o = owner_q;
  assign last_o  = last_q;

  a_r4_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARB_OWNED && !owner_req) |=> state_q == ARB_TURN);
  a_r4_owner_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ARB_OWNED |-> (owner_q != '0 && int'(owner_q) <= N));
  a_r7_host_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ARB_IDLE || state_q == ARB_TURN) && host_req_i) |=> state_q == ARB_HOST);
  a_r7_host_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARB_HOST && host_req_i) |=> state_q == ARB_HOST);
endmodule

// File: rtl/arb_req_ctrl.sv
`timescale 1ns/1ps
module arb_req_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic is_master_i,
  input  logic want_i,
  input  logic dma_i,
  input  logic done_i,
  input  logic host_req_i,
  input  logic core_prio_i,
  output logic req_o
);
  logic req_q, yield;

  assign yield = done_i && (!want_i || host_req_i || (dma_i && core_prio_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          req_q <= 1'b0;
    else if (is_master_i) req_q <= req_q && !yield;
    else                  req_q <= want_i && !(dma_i && core_prio_i);
  end

  assign req_o = req_q;

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master_i && !done_i) |=> $stable(req_o));
  a_r6_no_reraise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master_i && !req_o) |=> !req_o);
  a_r8_dma_backoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_master_i && dma_i && core_prio_i) |=> !req_o);
endmodule

// File: rtl/mp_bus_arbiter.sv
`timescale 1ns/1ps
module mp_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NODES = 6,
  parameter int ID_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  node_id_i,
  input  logic             rotate_i,
  input  logic [NODES-1:0] req_bus_i,
  output logic             req_o,
  input  logic             want_bus_i,
  input  logic             dma_xfer_i,
  input  logic             xfer_done_i,
  input  logic             host_req_i,
  output logic             host_gnt_no,
  input  logic             core_prio_i,
  output logic             core_prio_o,
  input  logic             suspend_i,
  output logic             bus_master_o,
  output logic             bus_drive_o,
  output logic             stall_o
);
  localparam logic [ID_W-1:0] ID_ONE = ID_W'(1);

  logic             single, is_master, susp_q, req_q, cp_in;
  logic [ID_W-1:0]  me, owner, last, grantor;
  logic [NODES-1:0] eff_req;
  arb_state_e       state;

  assign single  = (node_id_i == '0);
  assign me      = single ? ID_ONE : node_id_i;
  assign eff_req = single ? {{(NODES-1){1'b0}}, req_q} : req_bus_i;
  assign cp_in   = core_prio_i && !single;

  arb_tracker #(.N(NODES), .IW(ID_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_vec_i  (eff_req),
    .host_req_i (host_req_i),
    .rotate_i   (rotate_i),
    .state_o    (state),
    .owner_o    (owner),
    .last_o     (last)
  );

  assign is_master = (state == ARB_OWNED) && (owner == me);

  arb_req_ctrl u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .is_master_i (is_master),
    .want_i      (want_bus_i),
    .dma_i       (dma_xfer_i),
    .done_i      (xfer_done_i),
    .host_req_i  (host_req_i),
    .core_prio_i (cp_in),
    .req_o       (req_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) susp_q <= 1'b0;
    else         susp_q <= suspend_i;
  end

  assign grantor      = (last == '0) ? ID_ONE : last;
  assign req_o        = req_q;
  assign host_gnt_no  = !((state == ARB_HOST) && (grantor == me));
  assign core_prio_o  = want_bus_i && !dma_xfer_i && !is_master && !single;
  assign bus_master_o = is_master;
  assign bus_drive_o  = is_master && !susp_q;
  assign stall_o      = want_bus_i && (suspend_i || !is_master);

  a_r9_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |=> !bus_drive_o);
  a_r9_drive_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_drive_o |-> bus_master_o);
  a_r7_grant_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_gnt_no |-> $past(host_req_i));
  a_r4_no_direct_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_master_o) |-> $past(state) != ARB_OWNED);
  a_r7_no_master_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_gnt_no |-> !bus_master_o);
endmodule

// File: tb/mp_bus_arbiter_tb.sv
`timescale 1ns/1ps
module mp_bus_arbiter_tb;
  localparam int NN = 7;  // six arbitrating nodes plus one stand-alone node
  localparam int S_IDLE = 0, S_OWN = 1, S_TURN = 2, S_HOST = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rotate = 1'b0, host_req = 1'b0, suspend = 1'b0;
  logic [NN-1:0] want = '0, dma = '0, done = '0;
  logic [NN-1:0] req_w, mas, drv, gnt_n, cpo, stall;
  logic [5:0] req_bus;
  logic cp_bus;

  always #4 clk = ~clk;

  assign req_bus = req_w[5:0];
  assign cp_bus  = |cpo[5:0];

  for (genvar g = 0; g < NN; g++) begin : gen_node
    mp_bus_arbiter #(.NODES(6), .ID_W(3)) u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .node_id_i(3'((g < 6) ? g + 1 : 0)),
      .rotate_i(rotate), .req_bus_i(req_bus), .req_o(req_w[g]),
      .want_bus_i(want[g]), .dma_xfer_i(dma[g]), .xfer_done_i(done[g]),
      .host_req_i(host_req), .host_gnt_no(gnt_n[g]),
      .core_prio_i((g < 6) ? cp_bus : 1'b0), .core_prio_o(cpo[g]),
      .suspend_i(suspend), .bus_master_o(mas[g]), .bus_drive_o(drv[g]),
      .stall_o(stall[g])
    );
  end

  // reference model: system 0 = nodes 0..5, system 1 = node 6 alone
  int st[2], own[2], lst[2];
  logic [NN-1:0] mreq;
  logic suspq;
  int nchk = 0, nfail = 0;
  bit finished = 0;
  string cur_tag = "R10";

  function automatic int sys_of(int n); return (n < 6) ? 0 : 1; endfunction
  function automatic int me_of(int n);  return (n < 6) ? n + 1 : 1; endfunction
  function automatic bit m_master(int n);
    return st[sys_of(n)] == S_OWN && own[sys_of(n)] == me_of(n);
  endfunction
  function automatic bit m_cp();
    bit c = 0;
    for (int n = 0; n < 6; n++) if (want[n] && !dma[n] && !m_master(n)) c = 1;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin st[s] = S_IDLE; own[s] = 0; lst[s] = 0; end
      mreq = '0; suspq = 0;
    end else begin
      logic [NN-1:0] nreq;
      bit cp;
      cp = m_cp();
      for (int n = 0; n < NN; n++) begin
        bit cpi;
        cpi = (n < 6) ? cp : 0;
        if (m_master(n))
          nreq[n] = mreq[n] && !(done[n] && (!want[n] || host_req || (dma[n] && cpi)));
        else
          nreq[n] = want[n] && !(dma[n] && cpi);
      end
      for (int s = 0; s < 2; s++) begin
        logic [5:0] v;
        v = (s == 0) ? mreq[5:0] : {5'b0, mreq[6]};
        case (st[s])
          S_IDLE, S_TURN: begin
            if (host_req) st[s] = S_HOST;
            else if (v != 0) begin
              int start, w;
              start = (rotate && lst[s] < 6) ? lst[s] : 0;
              w = 0;
              for (int k = 0; k < 6; k++) begin
                int i;
                i = (start + k) % 6;
                if (w == 0 && v[i]) w = i + 1;
              end
              st[s] = S_OWN; own[s] = w;
            end else st[s] = S_IDLE;
          end
          S_OWN: if (!v[own[s]-1]) begin st[s] = S_TURN; lst[s] = own[s]; end
          default: if (!host_req) st[s] = S_TURN;
        endcase
      end
      mreq = nreq;
      suspq = suspend;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [NN-1:0] emas, edrv, egnt, ecp, est;
    for (int n = 0; n < NN; n++) begin
      int s, gr;
      s = sys_of(n);
      gr = (lst[s] == 0) ? 1 : lst[s];
      emas[n] = m_master(n);
      edrv[n] = emas[n] && !suspq;
      egnt[n] = !(st[s] == S_HOST && gr == me_of(n));
      ecp[n]  = (n < 6) && want[n] && !dma[n] && !emas[n];
      est[n]  = want[n] && (suspend || !emas[n]);
    end
    chk(mas[5:0] == emas[5:0], {cur_tag, " R4 R5 master"}, 32'(mas), 32'(emas));
    chk(mas[6] == emas[6], {cur_tag, " R12 stand-alone master"}, 32'(mas[6]), 32'(emas[6]));
    chk(req_w == mreq, {cur_tag, " R6 request"}, 32'(req_w), 32'(mreq));
    chk(gnt_n == egnt, {cur_tag, " R7 host grant"}, 32'(gnt_n), 32'(egnt));
    chk(drv == edrv && stall == est, {cur_tag, " R9 drive/stall"},
        32'({drv, stall}), 32'({edrv, est}));
    chk(cpo == ecp, {cur_tag, " R8 core priority"}, 32'(cpo), 32'(ecp));
    chk($countones(mas[5:0]) <= 1, "R11 single master", 32'(mas), 32'(0));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic go_idle();
    want = '0; done = '1; host_req = 0; suspend = 0; dma = '0;
    repeat (5) tick();
    done = '0;
    tick();
  endtask

  task automatic traffic(int cycles, bit use_dma, bit use_host, bit use_susp);
    for (int c = 0; c < cycles; c++) begin
      tick();
      for (int n = 0; n < NN; n++) begin
        if ($urandom % 8 == 0) want[n] = ~want[n];
        done[n] = ($urandom % 3 == 0);
        dma[n]  = use_dma ? 1'($urandom % 2) : 1'b0;
      end
      if (use_host && ($urandom % 16 == 0)) host_req = ~host_req;
      if (use_susp) suspend = ($urandom % 4 == 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nfail++;
      $display("FAIL R4 watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk(mas == '0, "R10 no master after reset", 32'(mas), 0);
    chk(gnt_n == '1, "R10 grants idle after reset", 32'(gnt_n), 32'h7f);
    chk(req_w == '0, "R10 no request after reset", 32'(req_w), 0);

    cur_tag = "R1";
    want[3] = 1; want[6] = 1;
    tick();
    chk(req_bus == 6'b001000, "R1 id 4 drives line 4", 32'(req_bus), 32'h08);
    tick();
    chk(mas == 7'b1001000, "R5 R12 owners one edge later", 32'(mas), 32'h48);
    want[3] = 0; want[6] = 0; done[3] = 1; done[6] = 1;
    tick();
    done = '0;
    tick();
    chk(mas == '0, "R4 turnaround has no master", 32'(mas), 0);
    tick();

    cur_tag = "R2";
    rotate = 0; want[1] = 1; want[4] = 1;
    tick(); tick();
    chk(mas[5:0] == 6'b000010, "R2 fixed: line 2 beats line 5", 32'(mas), 32'h02);
    want[1] = 0; done[1] = 1;
    tick();
    done = '0;
    tick();
    chk(mas[5:0] == '0, "R4 gap before next owner", 32'(mas), 0);
    tick();
    chk(mas[5:0] == 6'b010000, "R4 line 5 owns after gap", 32'(mas), 32'h10);
    go_idle();

    cur_tag = "R3";
    rotate = 1; want[0] = 1; want[5] = 1;
    tick(); tick();
    chk(mas[5:0] == 6'b100000, "R3 rotating: line 6 after owner 5", 32'(mas), 32'h20);
    go_idle();

    cur_tag = "R2"; rotate = 0; traffic(400, 0, 0, 0);
    cur_tag = "R3"; rotate = 1; traffic(400, 0, 0, 0);
    cur_tag = "R7"; traffic(600, 0, 1, 0);
    go_idle();
    cur_tag = "R7";
    host_req = 1;
    tick(); tick();
    chk(gnt_n[5:0] == ~6'(1 << (lst[0] == 0 ? 0 : lst[0] - 1)),
        "R7 last owner grants host", 32'(gnt_n), 0);
    host_req = 0;
    tick();
    cur_tag = "R8"; rotate = 0; traffic(600, 1, 0, 0);
    cur_tag = "R9"; traffic(400, 0, 0, 1);
    cur_tag = "R6"; rotate = 1; traffic(800, 1, 1, 1);
    go_idle();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule